// File: doc/BRIEF.md
# Three-Bit-Header Line Word Codec with Alternating Polarity

This block converts between 64-bit payload words and 67-bit line words. A line word is a self-synchronously scrambled body in the low bits and a 3-bit type header in the top bits. The header is left unscrambled. It says whether the body carries payload data or a control word. The two legal headers are bit complements of each other, so they are three bit flips apart. A majority vote therefore still recovers the word type when any one header bit is wrong.

Each legal header has one more one than zero, or one more zero than one. To keep the line balanced, the sender swaps the meaning of the two patterns on every word it sends. The receiver keeps a matching polarity register that advances on every received word. The receiver relies on the stream containing payload data regularly. If its polarity register has slipped by one word, data headers read as control. A long unbroken run of control words is taken as that sign of a slip, and the receiver then holds its polarity for one word to step back into line.

Both directions are pipelines of one register stage. The transmit and receive halves are independent, and each has its own valid qualifier.

Top module: `hdr67_codec`

## Requirements
- R1: Each cycle with `tx_valid` high produces `tx_out_valid` high one cycle later. A cycle with `tx_valid` low produces `tx_out_valid` low one cycle later.
- R2: The header sits in line word bits [66:64]. Data is sent as 3'b110 and control as 3'b001 when the transmit polarity is A, and the two are swapped when it is B. The polarity is A for the first word after reset and toggles on each accepted word only.
- R3: The line body in bits [63:0] is the payload scrambled with x^58 + x^39 + 1, bit 0 first. Each line bit is the payload bit XOR the line bits sent 39 and 58 bits earlier. The history is all zeros after reset.
- R4: Each cycle with `rx_valid` high gives `rx_out_valid` high one cycle later, with `rx_body` equal to the descrambled body. In loopback this equals the original payload.
- R5: A received header that equals a legal pattern for the receive polarity gives that word type, with `rx_corrected` low.
- R6: A received header with exactly one bit flipped still gives the transmitted word type, with `rx_corrected` high.
- R7: One flipped body bit at line position p corrupts exactly the descrambled bits at positions p, p+39 and p+58, counted across word boundaries.
- R8: When 8 consecutive received words (the bench setting of `RESYNC_LEN`) decode as control, `rx_slip` is raised with the eighth word. The receive polarity is then held for one word instead of toggling, and the following words decode correctly.
- R9: A cycle with `rx_valid` low gives `rx_out_valid` and `rx_slip` low one cycle later and does not advance the receive polarity.
- R10: After reset, `tx_out_valid`, `rx_out_valid`, `rx_corrected` and `rx_slip` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit word present |
| tx_is_ctrl | input | 1 | Transmit word is control (1) or data (0) |
| tx_body | input | BODY_W | Transmit payload |
| tx_out_valid | output | 1 | Line word present |
| tx_out_word | output | BODY_W+3 | Header and scrambled body |
| rx_valid | input | 1 | Received line word present |
| rx_word | input | BODY_W+3 | Received line word |
| rx_out_valid | output | 1 | Decoded word present |
| rx_is_ctrl | output | 1 | Decoded word type |
| rx_body | output | BODY_W | Descrambled payload |
| rx_corrected | output | 1 | Header needed single-bit correction |
| rx_slip | output | 1 | Control run reached the slip threshold; preceding types were misread |

## Verification
The header checks assume that at most one header bit per received word is damaged. The stimulus injects either no flip or a flip at a single random position into each header, and never more than one. The slip check assumes the stream does not contain control runs reaching the threshold unless the polarity has really slipped. The looped-back traffic therefore interleaves data often enough to keep control runs at two words. A slip is provoked only by feeding the receiver one extra word, which has no transmit counterpart.

// File: rtl/hdr67_pkg.sv
`timescale 1ns/1ps
package hdr67_pkg;

   localparam int HDR_W = 3;
   // data header while polarity A is in force; control is its complement
   localparam logic [HDR_W-1:0] HDR_DATA_A = 3'b110;

   typedef enum logic {POL_A = 1'b0, POL_B = 1'b1} pol_mode_e;

   function automatic pol_mode_e pol_flip(input pol_mode_e m);
      return (m == POL_A) ? POL_B : POL_A;
   endfunction

   function automatic logic [HDR_W-1:0] hdr_pattern(input logic is_ctrl, input pol_mode_e m);
      return (is_ctrl ^ (m == POL_B)) ? ~HDR_DATA_A : HDR_DATA_A;
   endfunction

endpackage

// File: rtl/hdr67_scr.sv
`timescale 1ns/1ps
module hdr67_scr #(
   parameter int W     = 64,
   parameter int LEN   = 58,
   parameter int TAP   = 39,
   parameter bit DESCR = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   localparam int EXT_W = LEN + W;

   // ext[LEN-1:0] is the line history (ext[LEN-1] newest), ext[LEN+i] is line bit i
   logic [LEN-1:0]   hist_q;
   logic [EXT_W-1:0] ext;

   generate
      if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
         $error("hdr67_scr: TAP must lie in 1..LEN-1");
      end

      if (DESCR) begin : g_descr
         // every line bit is known: output is a pure function of the line
         assign ext = {din, hist_q};
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign dout[i] = din[i] ^ ext[LEN + i - TAP] ^ ext[i];
         end
      end else begin : g_scr
         // line bits feed back into later line bits of the same word
         always_comb begin
            logic [EXT_W-1:0] e;
            e = {{W{1'b0}}, hist_q};
            for (int i = 0; i < W; i++) begin
               e[LEN + i] = din[i] ^ e[LEN + i - TAP] ^ e[i];
            end
            ext = e;
         end
         assign dout = ext[LEN +: W];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)  hist_q <= '0;
      else if (en) hist_q <= ext[W +: LEN];
   end

endmodule

// File: rtl/hdr67_hdr_dec.sv
`timescale 1ns/1ps
module hdr67_hdr_dec import hdr67_pkg::*; (
   input  logic [HDR_W-1:0] hdr,
   input  pol_mode_e        mode,
   output logic             is_ctrl,
   output logic             fixed
);
   logic [HDR_W-1:0] diff;
   int               n_diff;

   // distance to the data pattern of this polarity; the control pattern is its complement
   always_comb begin
      diff    = hdr ^ hdr_pattern(1'b0, mode);
      n_diff  = $countones(diff);
      is_ctrl = (n_diff > HDR_W / 2);
      fixed   = (n_diff != 0) && (n_diff != HDR_W);
   end

endmodule

// File: rtl/hdr67_rx_track.sv
`timescale 1ns/1ps
module hdr67_rx_track import hdr67_pkg::*; #(
   parameter int RESYNC_LEN = 1024
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      advance,
   input  logic      is_ctrl,
   output pol_mode_e mode,
   output logic      slip
);
   localparam int RUN_W = $clog2(RESYNC_LEN + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RESYNC_LEN - 1);

   pol_mode_e        mode_q;
   logic [RUN_W-1:0] run_q;

   assign mode = mode_q;
   assign slip = advance && is_ctrl && (run_q == RUN_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= POL_A;
         run_q  <= '0;
      end else if (advance) begin
         if (slip) begin
            // hold polarity one word to undo a one-word offset
            run_q <= '0;
         end else begin
            mode_q <= pol_flip(mode_q);
            run_q  <= is_ctrl ? run_q + 1'b1 : '0;
         end
      end
   end

endmodule

// File: rtl/hdr67_codec.sv
`timescale 1ns/1ps
module hdr67_codec import hdr67_pkg::*; #(
   parameter int BODY_W     = 64,
   parameter int SCR_LEN    = 58,
   parameter int SCR_TAP    = 39,
   parameter int RESYNC_LEN = 1024
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    tx_valid,
   input  logic                    tx_is_ctrl,
   input  logic [BODY_W-1:0]       tx_body,
   output logic                    tx_out_valid,
   output logic [BODY_W+HDR_W-1:0] tx_out_word,
   input  logic                    rx_valid,
   input  logic [BODY_W+HDR_W-1:0] rx_word,
   output logic                    rx_out_valid,
   output logic                    rx_is_ctrl,
   output logic [BODY_W-1:0]       rx_body,
   output logic                    rx_corrected,
   output logic                    rx_slip
);
   localparam int LINE_W = BODY_W + HDR_W;

   generate
      if (BODY_W < SCR_LEN) begin : g_bad_body
         $error("hdr67_codec: BODY_W must be at least SCR_LEN");
      end
      if (RESYNC_LEN < 2) begin : g_bad_resync
         $error("hdr67_codec: RESYNC_LEN must be at least 2");
      end
   endgenerate

   // ---------------- transmit ----------------
   pol_mode_e         tx_mode_q;
   logic [BODY_W-1:0] tx_scr;

   hdr67_scr #(.W(BODY_W), .LEN(SCR_LEN), .TAP(SCR_TAP), .DESCR(1'b0)) u_tx_scr (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (tx_valid),
      .din  (tx_body),
      .dout (tx_scr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_mode_q    <= POL_A;
         tx_out_valid <= 1'b0;
         tx_out_word  <= '0;
      end else begin
         tx_out_valid <= tx_valid;
         if (tx_valid) begin
            tx_out_word <= {hdr_pattern(tx_is_ctrl, tx_mode_q), tx_scr};
            tx_mode_q   <= pol_flip(tx_mode_q);
         end
      end
   end

   // ---------------- receive ----------------
   logic [BODY_W-1:0] rx_plain;
   pol_mode_e         rx_mode;
   logic              dec_ctrl;
   logic              dec_fixed;
   logic              trk_slip;

   hdr67_scr #(.W(BODY_W), .LEN(SCR_LEN), .TAP(SCR_TAP), .DESCR(1'b1)) u_rx_scr (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (rx_valid),
      .din  (rx_word[BODY_W-1:0]),
      .dout (rx_plain)
   );

   hdr67_hdr_dec u_dec (
      .hdr    (rx_word[LINE_W-1:BODY_W]),
      .mode   (rx_mode),
      .is_ctrl(dec_ctrl),
      .fixed  (dec_fixed)
   );

   hdr67_rx_track #(.RESYNC_LEN(RESYNC_LEN)) u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(rx_valid),
      .is_ctrl(dec_ctrl),
      .mode   (rx_mode),
      .slip   (trk_slip)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_out_valid <= 1'b0;
         rx_is_ctrl   <= 1'b0;
         rx_corrected <= 1'b0;
         rx_slip      <= 1'b0;
         rx_body      <= '0;
      end else begin
         rx_out_valid <= rx_valid;
         rx_is_ctrl   <= rx_valid & dec_ctrl;
         rx_corrected <= rx_valid & dec_fixed;
         rx_slip      <= trk_slip;
         if (rx_valid) rx_body <= rx_plain;
      end
   end

endmodule

// File: rtl/hdr67_codec_chk.sv
`timescale 1ns/1ps
module hdr67_codec_chk import hdr67_pkg::*; (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_valid,
   input logic             tx_is_ctrl,
   input logic             tx_out_valid,
   input logic [HDR_W-1:0] tx_out_hdr,
   input logic             rx_valid,
   input logic [HDR_W-1:0] rx_hdr,
   input logic             rx_out_valid,
   input logic             rx_is_ctrl,
   input logic             rx_corrected,
   input logic             rx_slip
);
   pol_mode_e chk_mode;
   logic      ctrl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_mode <= POL_A;
         ctrl_q   <= 1'b0;
      end else begin
         ctrl_q <= tx_is_ctrl;
         if (tx_out_valid) chk_mode <= pol_flip(chk_mode);
      end
   end

   // R1
   tx_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> tx_out_valid);
   // R1
   tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |=> !tx_out_valid);
   // R2
   tx_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_out_valid |-> tx_out_hdr == hdr_pattern(ctrl_q, chk_mode));
   // R5
   rx_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && (rx_hdr == HDR_DATA_A || rx_hdr == ~HDR_DATA_A)) |=> !rx_corrected);
   // R6
   rx_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_hdr != HDR_DATA_A && rx_hdr != ~HDR_DATA_A) |=> rx_corrected);
   // R9
   rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> (!rx_out_valid && !rx_slip));
   // R8
   rx_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_slip |-> (rx_out_valid && rx_is_ctrl));

endmodule

bind hdr67_codec hdr67_codec_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_valid    (tx_valid),
   .tx_is_ctrl  (tx_is_ctrl),
   .tx_out_valid(tx_out_valid),
   .tx_out_hdr  (tx_out_word[BODY_W+2:BODY_W]),
   .rx_valid    (rx_valid),
   .rx_hdr      (rx_word[BODY_W+2:BODY_W]),
   .rx_out_valid(rx_out_valid),
   .rx_is_ctrl  (rx_is_ctrl),
   .rx_corrected(rx_corrected),
   .rx_slip     (rx_slip)
);

// File: tb/test_hdr67_codec.sv
`timescale 1ns/1ps
module test_hdr67_codec;
   localparam int BW = 64;
   localparam int LW = 67;
   localparam int RL = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_valid = 1'b0, tx_is_ctrl = 1'b0;
   logic [BW-1:0] tx_body = '0;
   logic          tx_out_valid;
   logic [LW-1:0] tx_out_word;
   logic          rx_valid = 1'b0;
   logic [LW-1:0] rx_word = '0;
   logic          rx_out_valid, rx_is_ctrl, rx_corrected, rx_slip;
   logic [BW-1:0] rx_body;

   int n_total = 0;
   int n_fail  = 0;

   logic [57:0] mh = '0;
   logic        gen_mode = 1'b0;

   always #2.5 clk = ~clk;

   hdr67_codec #(.RESYNC_LEN(RL)) i_hdr67_codec (
      .clk(clk), .rst_n(rst_n),
      .tx_valid(tx_valid), .tx_is_ctrl(tx_is_ctrl), .tx_body(tx_body),
      .tx_out_valid(tx_out_valid), .tx_out_word(tx_out_word),
      .rx_valid(rx_valid), .rx_word(rx_word),
      .rx_out_valid(rx_out_valid), .rx_is_ctrl(rx_is_ctrl), .rx_body(rx_body),
      .rx_corrected(rx_corrected), .rx_slip(rx_slip)
   );

   // line model: x^58 + x^39 + 1, bit 0 first
   function automatic logic [BW-1:0] mscr(input logic [BW-1:0] d);
      logic [58+BW-1:0] e;
      e = {{BW{1'b0}}, mh};
      for (int i = 0; i < BW; i++) e[58+i] = d[i] ^ e[58+i-39] ^ e[i];
      mh = e[BW +: 58];
      return e[58 +: BW];
   endfunction

   function automatic logic [2:0] mhdr(input logic ctrl, input logic m);
      return (ctrl ^ m) ? 3'b001 : 3'b110;
   endfunction

   task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #1;
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      logic [BW-1:0] b;
      logic [BW-1:0] bq [3];
      logic [LW-1:0] line;
      logic [2:0]    err;
      logic          ctrl;

      repeat (3) tick();
      // R10 reset state
      chk("R10 tx_out_valid", LW'(tx_out_valid), '0);
      chk("R10 rx_out_valid", LW'(rx_out_valid), '0);
      chk("R10 rx_corrected", LW'(rx_corrected), '0);
      chk("R10 rx_slip",      LW'(rx_slip),      '0);
      rst_n = 1'b1;
      tick();

      // loopback sweep with idles and single header flips
      for (int k = 0; k < 48; k++) begin
         if (k % 6 == 5) begin
            tx_valid = 1'b0;
            rx_valid = 1'b0;
            tick();
            chk("R1 idle tx_out_valid", LW'(tx_out_valid), '0);
            chk("R9 idle rx_out_valid", LW'(rx_out_valid), '0);
            chk("R9 idle rx_slip",      LW'(rx_slip),      '0);
            continue;
         end
         ctrl = (k % 3 != 0);
         b    = {$urandom, $urandom};
         line = {mhdr(ctrl, gen_mode), mscr(b)};
         gen_mode = ~gen_mode;
         begin
            int e;
            e   = $urandom_range(0, 3);
            err = (e < 3) ? (3'b001 << e) : 3'b000;
         end
         tx_valid = 1'b1; tx_is_ctrl = ctrl; tx_body = b;
         rx_valid = 1'b1; rx_word = line ^ {err, {BW{1'b0}}};
         tick();
         chk("R1 tx_out_valid", LW'(tx_out_valid), LW'(1));
         chk("R2 header",       LW'(tx_out_word[66:64]), LW'(line[66:64]));
         chk("R3 body",         LW'(tx_out_word[63:0]),  LW'(line[63:0]));
         chk("R4 rx_out_valid", LW'(rx_out_valid), LW'(1));
         chk("R4 rx_body",      LW'(rx_body), LW'(b));
         if (err == 3'b000) begin
            chk("R5 type",      LW'(rx_is_ctrl),   LW'(ctrl));
            chk("R5 corrected", LW'(rx_corrected), '0);
         end else begin
            chk("R6 type",      LW'(rx_is_ctrl),   LW'(ctrl));
            chk("R6 corrected", LW'(rx_corrected), LW'(1));
         end
         chk("R8 no slip", LW'(rx_slip), '0);
      end

      // R7 body bit flip at position 20 of the first of three data words
      for (int j = 0; j < 3; j++) begin
         bq[j] = {$urandom, $urandom};
         line  = {mhdr(1'b0, gen_mode), mscr(bq[j])};
         gen_mode = ~gen_mode;
         if (j == 0) line[20] = ~line[20];
         tx_valid = 1'b1; tx_is_ctrl = 1'b0; tx_body = bq[j];
         rx_valid = 1'b1; rx_word = line;
         tick();
         if (j == 0) chk("R7 word0", LW'(rx_body), LW'(bq[0] ^ (64'd1 << 20) ^ (64'd1 << 59)));
         if (j == 1) chk("R7 word1", LW'(rx_body), LW'(bq[1] ^ (64'd1 << 14)));
         if (j == 2) chk("R7 word2", LW'(rx_body), LW'(bq[2]));
      end
      tx_valid = 1'b0;

      // R8: one extra receive word puts the receiver a word out of step
      b    = {$urandom, $urandom};
      line = {mhdr(1'b0, gen_mode), mscr(b)};
      rx_valid = 1'b1; rx_word = line;
      tick();
      chk("R5 extra word type", LW'(rx_is_ctrl), '0);
      chk("R4 extra word body", LW'(rx_body), LW'(b));
      for (int j = 1; j <= RL + 3; j++) begin
         b    = {$urandom, $urandom};
         line = {mhdr(1'b0, gen_mode), mscr(b)};
         gen_mode = ~gen_mode;
         rx_valid = 1'b1; rx_word = line;
         tick();
         chk("R4 slip phase body", LW'(rx_body), LW'(b));
         if (j <= RL) begin
            chk("R8 misread as control", LW'(rx_is_ctrl), LW'(1));
            chk("R8 slip flag", LW'(rx_slip), LW'(j == RL));
         end else begin
            chk("R8 realigned type", LW'(rx_is_ctrl), '0);
            chk("R8 realigned slip", LW'(rx_slip),    '0);
         end
      end
      rx_valid = 1'b0;
      tick();
      chk("R9 final idle", LW'(rx_out_valid), '0);

      summary();
      $finish;
   end

endmodule